// File: doc/BRIEF.md
# Reset Cause and Sleep Output Level Register Block

This block keeps two small pieces of state for the power manager. The first is a four-bit cause record: one sticky flag for each kind of reset the chip can take (power-on/hardware, watchdog expiry, wake from sleep, reset requested through a general-purpose pin). A one-cycle event pulse on the matching input sets each flag. Software reads the flags after boot to learn why the chip restarted, and clears them by writing ones.

The second is a 17-bit sleep level vector, one bit per general-purpose pin. For a pin set up as an output, the bit gives the level that pin drives while the chip sleeps. The vector goes straight to the pin controller. Hardware, watchdog and pin-requested resets wipe it. A wake-from-sleep reset leaves it alone, so the levels chosen before sleep stay in force.

Both registers sit behind a simple strobe-based word bus with registered read data. The cause record is at byte offset 0x0 and the level vector is at 0x4. Any other word reads as zero and ignores writes.

Top module: `rst_cause_regs`

## Requirements
- R1: After `rst_n` is released, a read of offset 0x0 returns 0x1 (only the hardware flag set) and `sleep_level` is all zeros.
- R2: A pulse on `ev_hw`, `ev_wdt`, `ev_slp` or `ev_gpio` sets cause bit 0, 1, 2 or 3 respectively at the next clock edge. Any other flags already set stay set.
- R3: A bus write to offset 0x0 clears every cause bit whose `bus_wdata` bit is 1. Bits written as 0 keep their value.
- R4: An `ev_hw` pulse leaves only bit 0 set, plus any of bits 1 to 3 whose own event arrives in the same cycle.
- R5: If a cause event and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R6: A bus write to offset 0x4 loads `bus_wdata[16:0]` into the level vector at the next edge. `sleep_level` shows the stored vector.
- R7: An `ev_hw`, `ev_wdt` or `ev_gpio` pulse clears the level vector to zero at the next edge, even if a level write arrives in the same cycle.
- R8: An `ev_slp` pulse on its own leaves the level vector unchanged. A level write in the same cycle still takes effect.
- R9: Reserved bits read as zero: bits [31:4] at 0x0 and bits [31:17] at 0x4. Offsets other than 0x0 and 0x4 read zero and ignore writes. Address bits [1:0] are not decoded.
- R10: A read strobe (`bus_sel` and `bus_rd`) loads `bus_rdata` at the next edge with the addressed register's value from before that edge, even when a write or event hits the same cycle. Without a read strobe, `bus_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ev_hw | input | 1 | One-cycle pulse: hardware reset occurred |
| ev_wdt | input | 1 | One-cycle pulse: watchdog reset occurred |
| ev_slp | input | 1 | One-cycle pulse: reset on exit from sleep |
| ev_gpio | input | 1 | One-cycle pulse: reset requested through a pin |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_rd | input | 1 | Read strobe, qualified by `bus_sel` |
| bus_addr | input | 4 | Byte address; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sleep_level | output | 17 | Sleep drive level per pin, to the pin controller |

## Verification
Two collisions matter here. The first is a reset event and a software write landing on the same register in the same cycle. The bench raises a watchdog pulse together with a write-one clear of the watchdog flag, and expects the flag to stay set. It also raises a pin-requested reset together with a level write, and expects the level vector to end up zero. A wake-from-sleep pulse together with a level write must let the write through.

The second collision is a read and a write to the same word in the same cycle. There the returned data must be the value from before the write, and the next read must show the new value.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int CAUSE_N = 4;
  localparam int CB_HW   = 0;
  localparam int CB_WDT  = 1;
  localparam int CB_SLP  = 2;
  localparam int CB_GPIO = 3;
  localparam logic [CAUSE_N-1:0] CAUSE_RST = 4'b0001;

  typedef enum logic [1:0] {
    SEL_CAUSE = 2'd0,
    SEL_LEVEL = 2'd1,
    SEL_NONE  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/rcs_cause_bank.sv
module rcs_cause_bank
  import rcs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_N-1:0] ev,
  input  logic               clr_we,
  input  logic [CAUSE_N-1:0] clr_mask,
  output logic [CAUSE_N-1:0] cause_q
);

  for (genvar i = 0; i < CAUSE_N; i++) begin : g_bit
    logic bit_d;
    logic bit_en;
    logic bit_q;

    if (i == CB_HW) begin : g_hw
      always_comb begin
        bit_en = ev[i] | (clr_we & clr_mask[i]);
        bit_d  = ev[i];
      end
    end else begin : g_other
      always_comb begin
        bit_en = ev[i] | ev[CB_HW] | (clr_we & clr_mask[i]);
        bit_d  = ev[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= CAUSE_RST[i];
      end else if (bit_en) begin
        bit_q <= bit_d;
      end
    end

    assign cause_q[i] = bit_q;
  end

endmodule

// File: rtl/rcs_level_reg.sv
module rcs_level_reg #(
  parameter int NUM_PINS = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                we,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] level_q
);

  logic [NUM_PINS-1:0] level_d;
  logic                level_en;

  always_comb begin
    level_en = clear | we;
    level_d  = clear ? '0 : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
    end else if (level_en) begin
      level_q <= level_d;
    end
  end

endmodule

// File: rtl/rcs_bus_port.sv
module rcs_bus_port
  import rcs_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int NUM_PINS = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [CAUSE_N-1:0]  cause_q,
  input  logic [NUM_PINS-1:0] level_q,
  output logic                cause_clr_we,
  output logic                level_we,
  output logic [DATA_W-1:0]   bus_rdata
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  reg_sel_e         reg_sel;
  logic [DATA_W-1:0] rdata_d;
  logic             rdata_en;
  logic [1:0]       unused_lsb;

  assign word_idx   = bus_addr[ADDR_W-1:2];
  assign unused_lsb = bus_addr[1:0];

  always_comb begin
    if (word_idx == IDX_W'(0)) begin
      reg_sel = SEL_CAUSE;
    end else if (word_idx == IDX_W'(1)) begin
      reg_sel = SEL_LEVEL;
    end else begin
      reg_sel = SEL_NONE;
    end
  end

  always_comb begin
    cause_clr_we = bus_sel & bus_wr & (reg_sel == SEL_CAUSE);
    level_we     = bus_sel & bus_wr & (reg_sel == SEL_LEVEL);
    rdata_en     = bus_sel & bus_rd;
    rdata_d      = '0;
    case (reg_sel)
      SEL_CAUSE: rdata_d[CAUSE_N-1:0]  = cause_q;
      SEL_LEVEL: rdata_d[NUM_PINS-1:0] = level_q;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rdata_en) begin
      bus_rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/rst_cause_regs.sv
module rst_cause_regs
  import rcs_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int NUM_PINS = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_hw,
  input  logic                ev_wdt,
  input  logic                ev_slp,
  input  logic                ev_gpio,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_PINS-1:0] sleep_level
);

  logic [CAUSE_N-1:0]  ev_vec;
  logic [CAUSE_N-1:0]  cause_q;
  logic [NUM_PINS-1:0] level_q;
  logic                cause_clr_we;
  logic                level_we;
  logic                level_clear;
  logic [DATA_W-NUM_PINS-1:0] unused_wdata;

  always_comb begin
    ev_vec          = '0;
    ev_vec[CB_HW]   = ev_hw;
    ev_vec[CB_WDT]  = ev_wdt;
    ev_vec[CB_SLP]  = ev_slp;
    ev_vec[CB_GPIO] = ev_gpio;
    level_clear     = ev_hw | ev_wdt | ev_gpio;
  end

  assign unused_wdata = bus_wdata[DATA_W-1:NUM_PINS];

  rcs_cause_bank u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev_vec),
    .clr_we   (cause_clr_we),
    .clr_mask (bus_wdata[CAUSE_N-1:0]),
    .cause_q  (cause_q)
  );

  rcs_level_reg #(.NUM_PINS(NUM_PINS)) u_level (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (level_clear),
    .we      (level_we),
    .wdata   (bus_wdata[NUM_PINS-1:0]),
    .level_q (level_q)
  );

  rcs_bus_port #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_PINS (NUM_PINS)
  ) u_bus (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .cause_q      (cause_q),
    .level_q      (level_q),
    .cause_clr_we (cause_clr_we),
    .level_we     (level_we),
    .bus_rdata    (bus_rdata)
  );

  assign sleep_level = level_q;

endmodule

// File: rtl/rcs_checker.sv
module rcs_checker
  import rcs_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int NUM_PINS = 17
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ev_hw,
  input logic                ev_wdt,
  input logic                ev_slp,
  input logic                ev_gpio,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_PINS-1:0] sleep_level,
  input logic [CAUSE_N-1:0]  cause_q
);

  localparam int IDX_W = ADDR_W - 2;

  logic [CAUSE_N-1:0] evs;
  logic at_cause, at_level, any_ev, lvl_clr;
  logic [DATA_W-1:0] unused_chk;

  assign evs      = {ev_gpio, ev_slp, ev_wdt, ev_hw};
  assign at_cause = bus_addr[ADDR_W-1:2] == IDX_W'(0);
  assign at_level = bus_addr[ADDR_W-1:2] == IDX_W'(1);
  assign any_ev   = |evs;
  assign lvl_clr  = ev_hw | ev_wdt | ev_gpio;
  assign unused_chk = bus_wdata;

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    any_ev |=> ((cause_q & $past(evs)) == $past(evs))); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && at_cause && !any_ev)
    |=> (cause_q == ($past(cause_q) & ~$past(bus_wdata[CAUSE_N-1:0])))); // R3

  AST_HW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hw |=> (cause_q == {$past(ev_gpio), $past(ev_slp), $past(ev_wdt), 1'b1})); // R4

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && at_cause && ev_wdt && bus_wdata[CB_WDT])
    |=> cause_q[CB_WDT]); // R5

  AST_LEVEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && at_level && !lvl_clr)
    |=> (sleep_level == $past(bus_wdata[NUM_PINS-1:0]))); // R6

  AST_LEVEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_clr |=> (sleep_level == '0)); // R7

  AST_SLEEP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_slp && !lvl_clr && !(bus_sel && bus_wr && at_level))
    |=> $stable(sleep_level)); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NUM_PINS] == '0); // R9

  AST_READ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_rd && at_cause)
    |=> (bus_rdata == {{(DATA_W-CAUSE_N){1'b0}}, $past(cause_q)})); // R10

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_rd) |=> $stable(bus_rdata)); // R10

endmodule

bind rst_cause_regs rcs_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .NUM_PINS (NUM_PINS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_hw       (ev_hw),
  .ev_wdt      (ev_wdt),
  .ev_slp      (ev_slp),
  .ev_gpio     (ev_gpio),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .sleep_level (sleep_level),
  .cause_q     (cause_q)
);

// File: tb/sim_rst_cause_regs.sv
`timescale 1ns/1ps
module sim_rst_cause_regs;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_hw, ev_wdt, ev_slp, ev_gpio;
  logic        bus_sel, bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [16:0] sleep_level;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  rst_cause_regs u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_hw(ev_hw), .ev_wdt(ev_wdt), .ev_slp(ev_slp), .ev_gpio(ev_gpio),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sleep_level(sleep_level)
  );

  // event field: bit0 hw, bit1 watchdog, bit2 sleep exit, bit3 pin reset
  typedef struct packed {
    logic [3:0]  ev;
    logic        wr;
    logic        rd;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [16:0] lvl;
    logic        chk_rd;
    logic [31:0] rdv;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{4'h0, 1'b0, 1'b1, 4'h0, 32'h0,         17'h00000, 1'b1, 32'h1,        8'd1},  // R1
    '{4'h0, 1'b1, 1'b0, 4'h4, 32'hFFFF_FFFF, 17'h1FFFF, 1'b0, 32'h0,        8'd6},  // R6
    '{4'h0, 1'b0, 1'b1, 4'h4, 32'h0,         17'h1FFFF, 1'b1, 32'h0001_FFFF, 8'd9}, // R9
    '{4'h4, 1'b0, 1'b0, 4'h0, 32'h0,         17'h1FFFF, 1'b0, 32'h0,        8'd8},  // R8
    '{4'h0, 1'b0, 1'b1, 4'h0, 32'h0,         17'h1FFFF, 1'b1, 32'h5,        8'd2},  // R2
    '{4'h0, 1'b1, 1'b0, 4'h0, 32'h1,         17'h1FFFF, 1'b0, 32'h0,        8'd3},  // R3
    '{4'h0, 1'b0, 1'b1, 4'h0, 32'h0,         17'h1FFFF, 1'b1, 32'h4,        8'd3},  // R3
    '{4'h2, 1'b0, 1'b0, 4'h0, 32'h0,         17'h00000, 1'b0, 32'h0,        8'd7},  // R7
    '{4'h0, 1'b1, 1'b0, 4'h4, 32'h0000_A5A5, 17'h0A5A5, 1'b0, 32'h0,        8'd6},  // R6
    '{4'h8, 1'b1, 1'b0, 4'h4, 32'h1,         17'h00000, 1'b0, 32'h0,        8'd7},  // R7
    '{4'h0, 1'b0, 1'b1, 4'h0, 32'h0,         17'h00000, 1'b1, 32'hE,        8'd2},  // R2
    '{4'h0, 1'b1, 1'b1, 4'h0, 32'h0,         17'h00000, 1'b1, 32'hE,        8'd10}, // R10
    '{4'h0, 1'b0, 1'b1, 4'h0, 32'h0,         17'h00000, 1'b1, 32'hE,        8'd3},  // R3
    '{4'h2, 1'b1, 1'b0, 4'h0, 32'h2,         17'h00000, 1'b0, 32'h0,        8'd5},  // R5
    '{4'h0, 1'b0, 1'b1, 4'h0, 32'h0,         17'h00000, 1'b1, 32'hE,        8'd5},  // R5
    '{4'h1, 1'b0, 1'b0, 4'h0, 32'h0,         17'h00000, 1'b0, 32'h0,        8'd4},  // R4
    '{4'h0, 1'b0, 1'b1, 4'h0, 32'h0,         17'h00000, 1'b1, 32'h1,        8'd4},  // R4
    '{4'h0, 1'b1, 1'b0, 4'h4, 32'h155,       17'h00155, 1'b0, 32'h0,        8'd6},  // R6
    '{4'h9, 1'b0, 1'b0, 4'h0, 32'h0,         17'h00000, 1'b0, 32'h0,        8'd7},  // R7
    '{4'h0, 1'b0, 1'b1, 4'h0, 32'h0,         17'h00000, 1'b1, 32'h9,        8'd4},  // R4
    '{4'h0, 1'b1, 1'b0, 4'h8, 32'hFFFF_FFFF, 17'h00000, 1'b0, 32'h0,        8'd9},  // R9
    '{4'h0, 1'b0, 1'b1, 4'h8, 32'h0,         17'h00000, 1'b1, 32'h0,        8'd9},  // R9
    '{4'h0, 1'b0, 1'b1, 4'h3, 32'h0,         17'h00000, 1'b1, 32'h9,        8'd9},  // R9
    '{4'h0, 1'b1, 1'b1, 4'h4, 32'h3,         17'h00003, 1'b1, 32'h0,        8'd10}, // R10
    '{4'h0, 1'b0, 1'b1, 4'h4, 32'h0,         17'h00003, 1'b1, 32'h3,        8'd10}, // R10
    '{4'h4, 1'b1, 1'b0, 4'h4, 32'hFFFF_FFFF, 17'h1FFFF, 1'b0, 32'h0,        8'd8},  // R8
    '{4'h0, 1'b0, 1'b1, 4'h0, 32'h0,         17'h1FFFF, 1'b1, 32'hD,        8'd2}   // R2
  };

  task automatic check(input string what, input int req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {ev_gpio, ev_slp, ev_wdt, ev_hw} = 4'h0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = 4'h0; bus_wdata = 32'h0;
  endtask

  task automatic step(input vec_t v);
    @(negedge clk);
    {ev_gpio, ev_slp, ev_wdt, ev_hw} = v.ev;
    bus_sel = v.wr | v.rd; bus_wr = v.wr; bus_rd = v.rd;
    bus_addr = v.addr; bus_wdata = v.wdata;
    @(posedge clk);
    #2;
    idle_inputs();
  endtask

  task automatic bus_read(input logic [3:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    #2;
    idle_inputs();
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    #20;
    check("level during reset", 1, {15'h0, sleep_level}, 32'h0);   // R1
    check("rdata during reset", 1, bus_rdata, 32'h0);              // R1
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i]);
      check($sformatf("vector %0d sleep_level", i), int'(TBL[i].req),
            {15'h0, sleep_level}, {15'h0, TBL[i].lvl});
      if (TBL[i].chk_rd)
        check($sformatf("vector %0d rdata", i), int'(TBL[i].req),
              bus_rdata, TBL[i].rdv);
    end

    // R10: read data holds while no read strobe is given
    repeat (3) @(negedge clk);
    check("rdata hold when idle", 10, bus_rdata, 32'hD);

    // R1: reset asserted mid-run restores the power-up state
    @(negedge clk);
    rst_n = 1'b0;
    #3;
    check("level cleared by rst_n", 1, {15'h0, sleep_level}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    bus_read(4'h0);
    check("cause after rst_n", 1, bus_rdata, 32'h1);
    bus_read(4'h4);
    check("level read after rst_n", 1, bus_rdata, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule